// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block sits beside a two-port shared memory. It watches the accesses that each port makes and keeps one interrupt flag for each port, so that the two sides can send each other short messages. The two highest addresses of the memory act as mailboxes. The top address belongs to the right port, and the address just below it belongs to the left port. When a port writes into the other side's mailbox, the owner's flag goes up. When the owner reads its own mailbox, its flag drops.

Both ports drive the block in the clock domain of the shared memory. A port counts as accessing the memory in any cycle where its select input is high. The write strobe picks between writing and reading, and a read also needs the output enable. Each port has a busy input that comes from the memory arbiter. While busy is high, that port's mailbox accesses have no effect on either flag. Each flag is a register, and it is presented active-low on its port. The message words and the memory array stay outside this block.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs `l_irq_n` and `r_irq_n` are high (inactive).
- R2: The right mailbox is the address with every bit set (2^AW-1), and the left mailbox is 2^AW-2. An access to any other address, or a port writing its own mailbox, leaves both flags unchanged.
- R3: A write by the left port (`l_sel`=1, `l_wr`=1, `l_busy`=0) to 2^AW-1 drives `r_irq_n` low from the next clock edge.
- R4: A write by the right port (`r_sel`=1, `r_wr`=1, `r_busy`=0) to 2^AW-2 drives `l_irq_n` low from the next clock edge.
- R5: A read by a port of its own mailbox (`sel`=1, `wr`=0, `oe`=1, busy=0) returns that port's interrupt output high from the next clock edge.
- R6: A read of the other port's mailbox, and a read with `oe`=0, leave both flags unchanged.
- R7: A write to the other port's mailbox while the writer's busy is high does not assert the other port's interrupt.
- R8: A read of its own mailbox while the reader's busy is high does not clear that port's interrupt.
- R9: When a set and a clear reach the same flag in one cycle, the flag ends up asserted (low).
- R10: With no qualifying access, each interrupt output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port access select, active high |
| l_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable, needed for a read |
| l_addr | input | AW | Left port address |
| l_busy | input | 1 | Left port busy from the arbiter, active high |
| r_sel | input | 1 | Right port access select, active high |
| r_wr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable, needed for a read |
| r_addr | input | AW | Right port address |
| r_busy | input | 1 | Right port busy from the arbiter, active high |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
A set and a clear can reach the same flag in one cycle. This happens when one port writes the other's mailbox while the owner reads that same mailbox. The bench provokes this with directed cycles for each flag, and it also lets random stimulus that is weighted toward the two mailbox addresses hit the case often. In every such cycle the bench's model applies the rule that the set wins, and it compares the resulting flag, seen at the port one edge later, with the model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned PORTS = 2;
    localparam int unsigned LEFT  = 0;
    localparam int unsigned RIGHT = 1;

    // one pending bit per port, 1 = interrupt raised
    typedef struct packed {
        logic [PORTS-1:0] pend;
    } mbx_state_t;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
    parameter int unsigned AW        = 16,
    parameter logic [AW-1:0] OWN_BOX = '1,
    parameter logic [AW-1:0] PEER_BOX = '1
) (
    input  logic          sel,
    input  logic          wr,
    input  logic          oe,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    output logic          set_peer,
    output logic          clr_own
);

    logic live;

    always_comb begin
        live     = sel && !busy;
        set_peer = live && wr && (addr == PEER_BOX);
        clr_own  = live && !wr && oe && (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbx_flag_next.sv
module mbx_flag_next (
    input  logic cur,
    input  logic set_req,
    input  logic clr_req,
    output logic nxt
);

    always_comb begin
        if (set_req) begin
            nxt = 1'b1;
        end else if (clr_req) begin
            nxt = 1'b0;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sel,
    input  logic          l_wr,
    input  logic          l_oe,
    input  logic [AW-1:0] l_addr,
    input  logic          l_busy,
    input  logic          r_sel,
    input  logic          r_wr,
    input  logic          r_oe,
    input  logic [AW-1:0] r_addr,
    input  logic          r_busy,
    output logic          l_irq_n,
    output logic          r_irq_n
);

    localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] L_BOX = R_BOX - 1'b1;

    logic [PORTS-1:0]   sel_v;
    logic [PORTS-1:0]   wr_v;
    logic [PORTS-1:0]   oe_v;
    logic [PORTS-1:0]   busy_v;
    logic [AW-1:0]      addr_v [PORTS];
    logic [PORTS-1:0]   set_peer;
    logic [PORTS-1:0]   clr_own;
    logic [PORTS-1:0]   set_in;
    logic [PORTS-1:0]   nxt_v;

    mbx_state_t st_d;
    mbx_state_t st_q;

    always_comb begin
        sel_v[LEFT]    = l_sel;
        sel_v[RIGHT]   = r_sel;
        wr_v[LEFT]     = l_wr;
        wr_v[RIGHT]    = r_wr;
        oe_v[LEFT]     = l_oe;
        oe_v[RIGHT]    = r_oe;
        busy_v[LEFT]   = l_busy;
        busy_v[RIGHT]  = r_busy;
        addr_v[LEFT]   = l_addr;
        addr_v[RIGHT]  = r_addr;
        // a flag is set by the opposite port
        set_in[LEFT]   = set_peer[RIGHT];
        set_in[RIGHT]  = set_peer[LEFT];
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam logic [AW-1:0] OWN  = (p == LEFT) ? L_BOX : R_BOX;
        localparam logic [AW-1:0] PEER = (p == LEFT) ? R_BOX : L_BOX;

        mbx_port_dec #(
            .AW       (AW),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) dec_i (
            .sel      (sel_v[p]),
            .wr       (wr_v[p]),
            .oe       (oe_v[p]),
            .addr     (addr_v[p]),
            .busy     (busy_v[p]),
            .set_peer (set_peer[p]),
            .clr_own  (clr_own[p])
        );

        mbx_flag_next nxt_i (
            .cur     (st_q.pend[p]),
            .set_req (set_in[p]),
            .clr_req (clr_own[p]),
            .nxt     (nxt_v[p])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = nxt_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_irq_n = ~st_q.pend[LEFT];
    assign r_irq_n = ~st_q.pend[RIGHT];

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_sel,
    input logic          l_wr,
    input logic          l_oe,
    input logic [AW-1:0] l_addr,
    input logic          l_busy,
    input logic          r_sel,
    input logic          r_wr,
    input logic          r_oe,
    input logic [AW-1:0] r_addr,
    input logic          r_busy,
    input logic          l_irq_n,
    input logic          r_irq_n
);

    localparam logic [AW-1:0] RB = {AW{1'b1}};
    localparam logic [AW-1:0] LB = RB - 1'b1;

    logic l_sets, r_sets, l_clrs, r_clrs;
    assign l_sets = l_sel && l_wr && !l_busy && (l_addr == RB);
    assign r_sets = r_sel && r_wr && !r_busy && (r_addr == LB);
    assign l_clrs = l_sel && !l_wr && l_oe && !l_busy && (l_addr == LB);
    assign r_clrs = r_sel && !r_wr && r_oe && !r_busy && (r_addr == RB);

    // R3, R9
    a_r3_left_write_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
        l_sets |=> !r_irq_n);
    // R4, R9
    a_r4_right_write_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
        r_sets |=> !l_irq_n);
    // R5
    a_r5_owner_read_clears_left: assert property (@(posedge clk) disable iff (!rst_n)
        (l_clrs && !r_sets) |=> l_irq_n);
    a_r5_owner_read_clears_right: assert property (@(posedge clk) disable iff (!rst_n)
        (r_clrs && !l_sets) |=> r_irq_n);
    // R7: right flag falls only after an unblocked left write
    a_r7_right_fall_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_irq_n) |-> $past(l_sets));
    a_r7_left_fall_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_irq_n) |-> $past(r_sets));
    // R8: a flag rises only after an unblocked owner read
    a_r8_right_rise_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_irq_n) |-> $past(r_clrs));
    a_r8_left_rise_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_irq_n) |-> $past(l_clrs));
    // R10
    a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sets && !r_sets && !l_clrs && !r_clrs) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.AW(AW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_sel   (l_sel),
    .l_wr    (l_wr),
    .l_oe    (l_oe),
    .l_addr  (l_addr),
    .l_busy  (l_busy),
    .r_sel   (r_sel),
    .r_wr    (r_wr),
    .r_oe    (r_oe),
    .r_addr  (r_addr),
    .r_busy  (r_busy),
    .l_irq_n (l_irq_n),
    .r_irq_n (r_irq_n)
);

// File: tb/mbx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_tb_top;

    localparam int unsigned AW = 16;
    localparam logic [AW-1:0] RB = {AW{1'b1}};
    localparam logic [AW-1:0] LB = RB - 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_wr = 0, l_oe = 0, l_busy = 0;
    logic r_sel = 0, r_wr = 0, r_oe = 0, r_busy = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit exp_l = 0;  // 1 = left interrupt pending
    bit exp_r = 0;

    always #2.5 clk = ~clk;

    mbx_irq_ctrl #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    function automatic bit model_next(bit cur, bit set_req, bit clr_req);
        if (set_req) return 1'b1;
        if (clr_req) return 1'b0;
        return cur;
    endfunction

    task automatic compare(string tag);
        checks++;
        if (l_irq_n !== ~exp_l || r_irq_n !== ~exp_r) begin
            fails++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected l_irq_n=%b r_irq_n=%b",
                     tag, l_irq_n, r_irq_n, ~exp_l, ~exp_r);
        end
    endtask

    // called at a falling edge: drive, update model, wait one cycle, compare
    task automatic step(input bit ls, lw, lo, lb, input logic [AW-1:0] la,
                        input bit rs, rw, ro, rb, input logic [AW-1:0] ra,
                        input string tag);
        bit sl, sr, cl, cr;
        l_sel = ls; l_wr = lw; l_oe = lo; l_busy = lb; l_addr = la;
        r_sel = rs; r_wr = rw; r_oe = ro; r_busy = rb; r_addr = ra;
        sr = ls && lw && !lb && (la == RB);
        sl = rs && rw && !rb && (ra == LB);
        cl = ls && !lw && lo && !lb && (la == LB);
        cr = rs && !rw && ro && !rb && (ra == RB);
        exp_l = model_next(exp_l, sl, cl);
        exp_r = model_next(exp_r, sr, cr);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag);
        step(0,0,0,0,'0, 0,0,0,0,'0, tag);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        case ($urandom % 4)
            0: return RB;
            1: return LB;
            2: return RB - 2;
            default: return AW'($urandom);
        endcase
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        step(1,1,0,0,RB, 0,0,0,0,'0, "R3 left sets right");
        step(0,0,0,0,'0, 1,1,0,0,LB, "R4 right sets left");
        idle("R10 hold");
        step(1,0,1,0,RB, 1,0,1,0,LB, "R6 peer reads keep flags");
        step(1,0,0,0,LB, 1,0,0,0,RB, "R6 read without oe keeps flags");
        step(1,0,1,1,LB, 1,0,1,1,RB, "R8 busy blocks clear");
        step(1,0,1,0,LB, 0,0,0,0,'0, "R5 left owner read clears");
        step(0,0,0,0,'0, 1,0,1,0,RB, "R5 right owner read clears");
        step(1,1,0,1,RB, 1,1,0,1,LB, "R7 busy blocks set");
        step(1,1,0,0,LB, 1,1,0,0,RB, "R2 own mailbox write ignored");
        step(1,1,0,0,RB-2, 1,1,0,0,RB-3, "R2 other address ignored");
        step(1,1,0,0,RB, 1,0,1,0,RB, "R9 right set wins over clear");
        step(1,0,1,0,LB, 1,1,0,0,LB, "R9 left set wins over clear");
        step(1,0,1,0,LB, 1,0,1,0,RB, "R5 both clear");

        for (int i = 0; i < 3000; i++) begin
            step($urandom%4 != 0, $urandom%2, $urandom%2, $urandom%4 == 0, pick_addr(),
                 $urandom%4 != 0, $urandom%2, $urandom%2, $urandom%4 == 0, pick_addr(),
                 "random R9 mix");
        end

        rst_n = 1'b0;
        exp_l = 0; exp_r = 0;
        #1;
        compare("R1 reset mid-run");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule